// File: doc/BRIEF.md
# Two-Cluster Instruction Steering Unit

This unit sits at the rename stage of a processor whose execution resources are split into two clusters. One instruction per cycle arrives with up to two source logical registers and an optional destination. In the same cycle the unit names the cluster that will execute it and raises a flag when a source value must first be copied across from the other cluster. A presence table holds two bits per logical register, one for each cluster that holds a readable copy. Two occupancy counters track how many steered instructions each cluster holds. The counters go up when an instruction is steered and go down on per-cluster retire pulses.

A two-bit mode input selects the policy. Simple, balanced and advanced modes all prefer the cluster that can read every source locally. They differ only in how they break the case where no such cluster exists. Simple mode uses a pseudo-random bit. Balanced mode picks the lighter cluster. Advanced mode first checks the load gap against a loadable threshold and, when the gap is too large, sends the instruction to the lighter cluster even if locality is lost. Modulo mode ignores dependences and alternates between clusters.

The modulo alternation is a two-state machine with states TURN_C0 and TURN_C1. Reset enters TURN_C0. On each accepted instruction in modulo mode, the transition TURN_C0 to TURN_C1 or TURN_C1 to TURN_C0 fires. Otherwise the state holds.

Top module: `clu_steer`

## Requirements
- R1: After reset, every logical register is present in cluster 0 only. Both occupancy counts are zero, the alternation state is TURN_C0, the threshold is 8, and the 16-bit LFSR holds 16'hACE1.
- R2: In the simple, balanced and advanced modes (advanced only when not overridden), the instruction goes to a cluster that holds all its valid sources. When both clusters qualify (no valid source, or every source replicated), cluster 0 is chosen.
- R3: In simple mode (steer_mode 2'b00), when neither cluster holds all sources, the cluster is bit 0 of the LFSR. The LFSR shifts left on every accepted instruction in any mode, with new bit 0 = b15^b13^b12^b10.
- R4: In balanced mode (2'b01), when neither cluster holds all sources, the cluster with the smaller count is chosen, and a tie picks cluster 0.
- R5: In advanced mode (2'b10), when the absolute count difference is strictly greater than the threshold, the lighter cluster is chosen regardless of source locations. Otherwise the R2 and R4 rules apply.
- R6: In modulo mode (2'b11), steer_cluster follows the alternation state regardless of sources. The state toggles only on accepted modulo-mode instructions.
- R7: copy_needed is high exactly when some valid source is absent from the chosen cluster.
- R8: On an accepted instruction, each valid source gains presence in the chosen cluster while keeping its other copy. The destination then becomes present in the chosen cluster only, and the destination update wins if it names a source.
- R9: A cluster's count rises by one when an instruction is steered to it and falls by one on its retire pulse. Both in one cycle leave it unchanged. It saturates at all-ones and never goes below zero.
- R10: A thr_load pulse stores thr_value as the threshold used from the next cycle on.
- R11: With ins_valid low, steer_valid is low and no presence bit, count (apart from retire pulses), alternation state or LFSR changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Instruction present this cycle |
| src_a_valid | input | 1 | First source is used |
| src_a_reg | input | AW | First source logical register |
| src_b_valid | input | 1 | Second source is used |
| src_b_reg | input | AW | Second source logical register |
| dst_valid | input | 1 | Destination is written |
| dst_reg | input | AW | Destination logical register |
| steer_mode | input | 2 | 00 simple, 01 balanced, 10 advanced, 11 modulo |
| thr_load | input | 1 | Load new imbalance threshold |
| thr_value | input | CNT_W | Threshold value to load |
| retire_c0 | input | 1 | One instruction leaves cluster 0 |
| retire_c1 | input | 1 | One instruction leaves cluster 1 |
| steer_valid | output | 1 | Decision valid this cycle |
| steer_cluster | output | 1 | Chosen cluster |
| copy_needed | output | 1 | A source must be copied into the chosen cluster |

## Verification
The bench targets several corner cases, each with a distinct failure signature.
- Replicated sources and source-less instructions: a design that mishandled them would send them to cluster 1 or flag a needless copy.
- A destination that is also a source: a wrong update order would leave the destination visible in both clusters and hide a later copy.
- Load gaps equal to and one above the threshold: an off-by-one compare would override locality one case early or late.
- Counters pushed past all-ones and drained below zero: a wrapping counter would reverse every later balanced decision.
- Idle cycles carrying register fields and modulo toggling in other modes: either defect would shift the alternation or the LFSR sequence seen afterwards.

// File: rtl/clu_steer_pkg.sv
package clu_steer_pkg;
    typedef enum logic [1:0] {
        MODE_SIMPLE   = 2'd0,
        MODE_BALANCED = 2'd1,
        MODE_ADVANCED = 2'd2,
        MODE_MODULO   = 2'd3
    } steer_mode_e;

    typedef enum logic {
        TURN_C0 = 1'b0,
        TURN_C1 = 1'b1
    } turn_e;

    localparam int unsigned NUM_CLU   = 2;
    localparam int unsigned LFSR_W    = 16;
    localparam logic [15:0] LFSR_SEED = 16'hACE1;
endpackage

// File: rtl/clu_map_table.sv
module clu_map_table #(
    parameter int NLREG = 32,
    parameter int AW    = $clog2(NLREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_a,
    input  logic [AW-1:0] rd_b,
    output logic [1:0]    pres_a,
    output logic [1:0]    pres_b,
    input  logic          upd_en,
    input  logic          sa_v,
    input  logic          sb_v,
    input  logic          d_v,
    input  logic [AW-1:0] d_reg,
    input  logic          clu
);
    logic [1:0] map_q [NLREG];
    logic [1:0] clu_bit;

    assign clu_bit = clu ? 2'b10 : 2'b01;
    assign pres_a  = map_q[rd_a];
    assign pres_b  = map_q[rd_b];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NLREG; i++) map_q[i] <= 2'b01;
        end else if (upd_en) begin
            if (sa_v) map_q[rd_a] <= map_q[rd_a] | clu_bit;
            if (sb_v) map_q[rd_b] <= map_q[rd_b] | clu_bit;
            if (d_v)  map_q[d_reg] <= clu_bit;
        end
    end

    // R8
    dst_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && d_v) |=> (map_q[$past(d_reg)] == $past(clu_bit)));

    // R8
    pres_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pres_a != 2'b00) && (pres_b != 2'b00));
endmodule

// File: rtl/clu_load_ctr.sv
module clu_load_ctr #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (inc && !dec) begin
            if (cnt != CMAX) cnt <= cnt + 1'b1;
        end else if (dec && !inc) begin
            if (cnt != '0) cnt <= cnt - 1'b1;
        end
    end

    // R9
    ctr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc == dec) |=> $stable(cnt));

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !dec && cnt == CMAX) |=> (cnt == CMAX));

    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc && cnt == '0) |=> (cnt == '0));
endmodule

// File: rtl/clu_turn_fsm.sv
module clu_turn_fsm
    import clu_steer_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  adv_turn,
    input  logic  adv_lfsr,
    output turn_e turn,
    output logic  rnd_bit
);
    turn_e             state_q, state_d;
    logic [LFSR_W-1:0] lfsr_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TURN_C0: if (adv_turn) state_d = TURN_C1;
            TURN_C1: if (adv_turn) state_d = TURN_C0;
            default: state_d = TURN_C0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TURN_C0;
            lfsr_q  <= LFSR_SEED;
        end else begin
            state_q <= state_d;
            if (adv_lfsr)
                lfsr_q <= {lfsr_q[14:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
        end
    end

    always_comb begin
        turn    = state_q;
        rnd_bit = lfsr_q[0];
    end

    // R6
    turn_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv_turn |=> (state_q != $past(state_q)));

    // R3
    lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(lfsr_q) != 0);
endmodule

// File: rtl/clu_policy.sv
module clu_policy
    import clu_steer_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  steer_mode_e      mode,
    input  logic             sa_v,
    input  logic             sb_v,
    input  logic [1:0]       pres_a,
    input  logic [1:0]       pres_b,
    input  logic [CNT_W-1:0] cnt0,
    input  logic [CNT_W-1:0] cnt1,
    input  logic [CNT_W-1:0] thr,
    input  turn_e            turn,
    input  logic             rnd_bit,
    output logic             clu,
    output logic             copy
);
    logic             feas0, feas1, lighter1, over;
    logic [CNT_W-1:0] gap;
    logic             bal_pick;

    always_comb begin
        feas0    = (!sa_v || pres_a[0]) && (!sb_v || pres_b[0]);
        feas1    = (!sa_v || pres_a[1]) && (!sb_v || pres_b[1]);
        lighter1 = cnt1 < cnt0;
        gap      = (cnt0 >= cnt1) ? (cnt0 - cnt1) : (cnt1 - cnt0);
        over     = gap > thr;
        bal_pick = feas0 ? 1'b0 : (feas1 ? 1'b1 : lighter1);
        unique case (mode)
            MODE_SIMPLE:   clu = feas0 ? 1'b0 : (feas1 ? 1'b1 : rnd_bit);
            MODE_BALANCED: clu = bal_pick;
            MODE_ADVANCED: clu = over ? lighter1 : bal_pick;
            MODE_MODULO:   clu = turn;
            default:       clu = 1'b0;
        endcase
        copy = (sa_v && !pres_a[clu]) || (sb_v && !pres_b[clu]);
    end
endmodule

// File: rtl/clu_steer.sv
module clu_steer
    import clu_steer_pkg::*;
#(
    parameter int NLREG          = 32,
    parameter int CNT_W          = 7,
    parameter int IMB_THRESH_DEF = 8,
    parameter int AW             = $clog2(NLREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_valid,
    input  logic             src_a_valid,
    input  logic [AW-1:0]    src_a_reg,
    input  logic             src_b_valid,
    input  logic [AW-1:0]    src_b_reg,
    input  logic             dst_valid,
    input  logic [AW-1:0]    dst_reg,
    input  logic [1:0]       steer_mode,
    input  logic             thr_load,
    input  logic [CNT_W-1:0] thr_value,
    input  logic             retire_c0,
    input  logic             retire_c1,
    output logic             steer_valid,
    output logic             steer_cluster,
    output logic             copy_needed
);
    steer_mode_e      mode;
    logic [1:0]       pres_a, pres_b;
    logic [CNT_W-1:0] cnt [NUM_CLU];
    logic [NUM_CLU-1:0] inc_v, dec_v;
    logic [CNT_W-1:0] thr_q;
    turn_e            turn;
    logic             rnd_bit, clu, copy;

    assign mode  = steer_mode_e'(steer_mode);
    assign dec_v = {retire_c1, retire_c0};
    assign inc_v = {ins_valid && clu, ins_valid && !clu};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        thr_q <= CNT_W'(IMB_THRESH_DEF);
        else if (thr_load) thr_q <= thr_value;
    end

    clu_map_table #(.NLREG(NLREG), .AW(AW)) map_i (
        .clk(clk), .rst_n(rst_n),
        .rd_a(src_a_reg), .rd_b(src_b_reg),
        .pres_a(pres_a), .pres_b(pres_b),
        .upd_en(ins_valid), .sa_v(src_a_valid), .sb_v(src_b_valid),
        .d_v(dst_valid), .d_reg(dst_reg), .clu(clu)
    );

    for (genvar g = 0; g < NUM_CLU; g++) begin : g_ctr
        clu_load_ctr #(.CNT_W(CNT_W)) ctr_i (
            .clk(clk), .rst_n(rst_n),
            .inc(inc_v[g]), .dec(dec_v[g]), .cnt(cnt[g])
        );
    end

    clu_turn_fsm turn_i (
        .clk(clk), .rst_n(rst_n),
        .adv_turn(ins_valid && mode == MODE_MODULO),
        .adv_lfsr(ins_valid),
        .turn(turn), .rnd_bit(rnd_bit)
    );

    clu_policy #(.CNT_W(CNT_W)) pol_i (
        .mode(mode), .sa_v(src_a_valid), .sb_v(src_b_valid),
        .pres_a(pres_a), .pres_b(pres_b),
        .cnt0(cnt[0]), .cnt1(cnt[1]), .thr(thr_q),
        .turn(turn), .rnd_bit(rnd_bit),
        .clu(clu), .copy(copy)
    );

    assign steer_valid   = ins_valid;
    assign steer_cluster = clu;
    assign copy_needed   = ins_valid && copy;

    // R2
    locality_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && (mode == MODE_SIMPLE || mode == MODE_BALANCED)
         && (!src_a_valid || pres_a[0]) && (!src_b_valid || pres_b[0]))
        |-> (!steer_cluster && !copy_needed));

    // R5
    override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && mode == MODE_ADVANCED
         && {1'b0, cnt[0]} > ({1'b0, cnt[1]} + {1'b0, thr_q}))
        |-> steer_cluster);

    // R10
    thr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        thr_load |=> (thr_q == $past(thr_value)));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ins_valid |-> (!steer_valid && !copy_needed));
endmodule

// File: tb/clu_steer_tb.sv
module clu_steer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NLREG = 32;
    localparam int CNT_W = 7;
    localparam int AW = 5;
    localparam int CMAX = 127;

    logic clk = 0, rst_n = 0;
    logic ins_valid = 0, src_a_valid = 0, src_b_valid = 0, dst_valid = 0;
    logic [AW-1:0] src_a_reg = 0, src_b_reg = 0, dst_reg = 0;
    logic [1:0] steer_mode = 0;
    logic thr_load = 0;
    logic [CNT_W-1:0] thr_value = 0;
    logic retire_c0 = 0, retire_c1 = 0;
    logic steer_valid, steer_cluster, copy_needed;

    int n_cmp = 0, n_err = 0;
    bit done = 0;

    // reference model state
    bit [1:0] m_map [NLREG];
    int m_c0, m_c1, m_thr;
    bit m_turn;
    bit [15:0] m_lfsr;

    always #(CLK_PERIOD/2) clk = ~clk;

    clu_steer #(.NLREG(NLREG), .CNT_W(CNT_W), .IMB_THRESH_DEF(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid),
        .src_a_valid(src_a_valid), .src_a_reg(src_a_reg),
        .src_b_valid(src_b_valid), .src_b_reg(src_b_reg),
        .dst_valid(dst_valid), .dst_reg(dst_reg), .steer_mode(steer_mode),
        .thr_load(thr_load), .thr_value(thr_value),
        .retire_c0(retire_c0), .retire_c1(retire_c1),
        .steer_valid(steer_valid), .steer_cluster(steer_cluster),
        .copy_needed(copy_needed)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit exp_cluster(bit sav, int sa, bit sbv, int sb, int md);
        bit f0, f1, light1, bal;
        int gap;
        f0 = (!sav || m_map[sa][0]) && (!sbv || m_map[sb][0]);
        f1 = (!sav || m_map[sa][1]) && (!sbv || m_map[sb][1]);
        light1 = m_c1 < m_c0;
        gap = (m_c0 > m_c1) ? m_c0 - m_c1 : m_c1 - m_c0;
        bal = f0 ? 1'b0 : (f1 ? 1'b1 : light1);
        case (md)
            0: return f0 ? 1'b0 : (f1 ? 1'b1 : m_lfsr[0]);  // R3
            1: return bal;                                   // R4
            2: return (gap > m_thr) ? light1 : bal;          // R5
            default: return m_turn;                          // R6
        endcase
    endfunction

    task automatic step(input bit v, input bit sav, input int sa, input bit sbv, input int sb,
                        input bit dv, input int d, input int md,
                        input bit tl, input int tv, input bit r0, input bit r1, input string tag);
        bit ec, ecp;
        @(negedge clk);
        ins_valid = v; src_a_valid = sav; src_a_reg = AW'(sa);
        src_b_valid = sbv; src_b_reg = AW'(sb); dst_valid = dv; dst_reg = AW'(d);
        steer_mode = 2'(md); thr_load = tl; thr_value = CNT_W'(tv);
        retire_c0 = r0; retire_c1 = r1;
        #1;
        ec = exp_cluster(sav, sa, sbv, sb, md);
        ecp = (sav && !m_map[sa][ec]) || (sbv && !m_map[sb][ec]);
        chk(steer_valid == v, "R11 steer_valid", steer_valid, v);
        if (v) begin
            chk(steer_cluster == ec, tag, steer_cluster, ec);
            chk(copy_needed == ecp, "R7 copy_needed", copy_needed, ecp);
        end else begin
            chk(copy_needed == 1'b0, "R11 copy_needed idle", copy_needed, 0);
        end
        // model update (R8, R9, R10, R3, R6)
        if (v) begin
            if (sav) m_map[sa] = m_map[sa] | (ec ? 2'b10 : 2'b01);
            if (sbv) m_map[sb] = m_map[sb] | (ec ? 2'b10 : 2'b01);
            if (dv)  m_map[d]  = ec ? 2'b10 : 2'b01;
            if (md == 3) m_turn = !m_turn;
            m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
        end
        begin
            bit i0, i1;
            i0 = v && !ec; i1 = v && ec;
            if (i0 && !r0) m_c0 = (m_c0 < CMAX) ? m_c0 + 1 : m_c0;
            else if (r0 && !i0) m_c0 = (m_c0 > 0) ? m_c0 - 1 : 0;
            if (i1 && !r1) m_c1 = (m_c1 < CMAX) ? m_c1 + 1 : m_c1;
            else if (r1 && !i1) m_c1 = (m_c1 > 0) ? m_c1 - 1 : 0;
        end
        if (tl) m_thr = tv;
    endtask

    function automatic string mode_tag(int md);
        case (md)
            0: return "R3 simple";
            1: return "R4 balanced";
            2: return "R5 advanced";
            default: return "R6 modulo";
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 1234;
        void'($urandom(seed));
        for (int i = 0; i < NLREG; i++) m_map[i] = 2'b01;
        m_c0 = 0; m_c1 = 0; m_thr = 8; m_turn = 0; m_lfsr = 16'hACE1;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: idle after reset, then reset mapping is cluster 0 only
        step(0, 1, 5, 1, 9, 1, 5, 0, 0, 0, 0, 0, "R1 idle");
        step(1, 1, 5, 1, 9, 0, 0, 0, 0, 0, 0, 0, "R1 reset map");
        // R6: modulo alternation, place reg 3 in cluster 1
        step(1, 0, 0, 0, 0, 0, 0, 3, 0, 0, 0, 0, "R6 modulo first");
        step(1, 0, 0, 0, 0, 1, 3, 3, 0, 0, 0, 0, "R6 modulo second");
        step(1, 1, 3, 0, 0, 1, 4, 3, 0, 0, 0, 0, "R6 modulo third copy");
        // R2: replicated source and sourceless instruction
        step(1, 1, 3, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R2 replicated");
        step(1, 0, 0, 0, 0, 0, 0, 2, 0, 0, 0, 0, "R2 no source");
        // R11: idle does not toggle modulo state or touch map
        step(0, 1, 3, 0, 0, 1, 3, 3, 0, 0, 0, 0, "R11 idle modulo");
        step(1, 0, 0, 0, 0, 1, 6, 3, 0, 0, 0, 0, "R6 after idle");
        // R4: conflicting sources, balanced fallback
        step(1, 1, 4, 1, 6, 1, 7, 1, 0, 0, 0, 0, "R4 conflict");
        // R8: destination equal to a source
        step(1, 1, 7, 0, 0, 1, 7, 3, 0, 0, 0, 0, "R8 dst is src");
        step(1, 1, 7, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R8 dst exclusive");
        // R3: simple-mode conflict uses LFSR bit
        step(1, 1, 4, 1, 6, 0, 0, 3, 0, 0, 0, 0, "R6 setup");
        step(1, 1, 1, 1, 7, 0, 0, 0, 0, 0, 0, 0, "R3 random");
        // R10 / R5: threshold boundaries
        step(1, 0, 0, 0, 0, 0, 0, 1, 1, 0, 1, 1, "R10 load zero");
        for (int k = 0; k < 3; k++)
            step(1, 0, 0, 0, 0, 1, 10, 1, 0, 0, 0, 0, "R2 pile c0");
        step(1, 1, 10, 0, 0, 0, 0, 2, 0, 0, 0, 0, "R5 override");
        step(1, 0, 0, 0, 0, 0, 0, 1, 1, 40, 0, 0, "R10 load large");
        step(1, 1, 10, 0, 0, 0, 0, 2, 0, 0, 0, 0, "R5 below thr");
        // R9: saturation and drain
        for (int k = 0; k < 140; k++)
            step(1, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R9 saturate");
        for (int k = 0; k < 135; k++)
            step(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 1, 1, "R9 drain");
        step(1, 1, 4, 1, 6, 0, 0, 1, 0, 0, 0, 0, "R9 after drain");
        step(1, 0, 0, 0, 0, 0, 0, 1, 0, 0, 1, 1, "R9 inc and dec");
        step(1, 0, 0, 0, 0, 0, 0, 1, 1, 8, 0, 0, "R10 restore");

        // constrained random
        for (int k = 0; k < 4000; k++) begin
            int md;
            md = $urandom % 4;
            step(($urandom % 8) != 0, $urandom % 2, $urandom % 8, $urandom % 2, $urandom % 8,
                 $urandom % 2, $urandom % 8, md,
                 ($urandom % 64) == 0, $urandom % 12,
                 ($urandom % 3) == 0, ($urandom % 3) == 0, mode_tag(md));
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end
endmodule